// File: doc/BRIEF.md
# Register-File LIFO with Occupancy Flags

This block is a last-in, first-out store of 64 words held in flip-flops. A single six-bit top pointer addresses the words, and two status flags report whether the store is completely occupied or holds nothing. On a push the pointer advances first and the incoming word is written at the advanced position. On a pop the word under the pointer is copied into a registered output, and then the pointer steps back. Each accepted request updates the pointer, the flags and the storage within one clock edge.

The pointer wraps naturally modulo 64. After reset it rests at 0, so the first pushed word lands at position 1 and the 64th lands at position 0. The store is therefore full exactly when a push leaves the pointer at zero, and empty exactly when a pop leaves it at zero.

A request that cannot be honoured leaves all state untouched and raises the error output for one cycle. Such requests are a push into a full store, a pop from an empty store, or a push and a pop asserted together. The data width is a parameter (default 8 bits).

Top module: `lifo_regstack`

## Requirements
- R1: While reset is held and in the first cycle after it, `empty_o` is 1, `full_o` is 0, `err_o` is 0 and `rd_data` is 0.
- R2: A pop accepted at a clock edge places, in `rd_data` after that edge, the most recently pushed word that has not yet been popped.
- R3: An accepted push clears `empty_o` after the edge. The 64th word pushed into an empty store sets `full_o` after the edge, because the pointer has wrapped to 0.
- R4: An accepted pop clears `full_o` after the edge. A pop that removes the only remaining word sets `empty_o` after the edge.
- R5: A push alone while `full_o` is 1 sets `err_o` for the next cycle and changes neither the flags, `rd_data` nor the stored words.
- R6: A pop alone while `empty_o` is 1 sets `err_o` for the next cycle and leaves the flags and `rd_data` unchanged.
- R7: Push and pop asserted in the same cycle set `err_o` for the next cycle, and neither operation takes effect.
- R8: `err_o` is 0 in every cycle that follows an edge with no request or with an accepted request, so an error lasts exactly one cycle per faulty request.
- R9: `rd_data` holds its value across every edge that does not accept a pop.
- R10: A full store of 64 words, including the word written at pointer position 0 after wraparound, pops back in exact reverse order of pushing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Request to push `wr_data` |
| pop_i | input | 1 | Request to pop the top word |
| wr_data | input | DATA_W | Word to push |
| rd_data | output | DATA_W | Registered word returned by the last accepted pop |
| full_o | output | 1 | All 64 positions occupied |
| empty_o | output | 1 | No word stored |
| err_o | output | 1 | One-cycle pulse after a rejected request |

## Verification
A pointer that steps wrongly shows up on the first pop after it: `rd_data` returns a stale or neighbouring word one cycle after that pop. A pointer fault also shows as a flag that asserts at the wrong occupancy, visible one cycle after the faulting push or pop. A corrupted flag turns the next legal request into a rejected one, or the reverse, which is seen at `err_o` in the following cycle. A word damaged by a rejected push stays hidden until the store drains to that depth. For this reason the bench always pops a full store completely after testing rejected pushes against it.

// File: rtl/regstack_pkg.sv
package regstack_pkg;

  typedef enum logic [1:0] {
    REQ_IDLE = 2'd0,
    REQ_PUSH = 2'd1,
    REQ_POP  = 2'd2,
    REQ_BAD  = 2'd3
  } req_e;

  // Decide what a request does given the current occupancy flags.
  function automatic req_e classify(input logic push, input logic pop,
                                    input logic full, input logic empty);
    if (push && pop) return REQ_BAD;
    if (push)        return full  ? REQ_BAD : REQ_PUSH;
    if (pop)         return empty ? REQ_BAD : REQ_POP;
    return REQ_IDLE;
  endfunction

endpackage

// File: rtl/lifo_regstack_store.sv
module lifo_regstack_store #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [PTR_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << PTR_W;

  logic [DATA_W-1:0] word_q [DEPTH];
  logic [DATA_W-1:0] rd_q;

  // One register per position, each with its own address match.
  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic sel;
    assign sel = we_i && (waddr_i == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (sel) word_q[g] <= wdata_i;
    end
  end

  // Output register: loads only on an accepted pop.
  always_ff @(posedge clk) begin
    if (!rst_n)    rd_q <= '0;
    else if (re_i) rd_q <= word_q[raddr_i];
  end

  assign rdata_o = rd_q;

endmodule

// File: rtl/lifo_regstack_ctrl.sv
module lifo_regstack_ctrl
  import regstack_pkg::*;
#(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  output logic             do_push_o,
  output logic             do_pop_o,
  output logic             bad_req_o,
  output logic [PTR_W-1:0] wr_addr_o,
  output logic [PTR_W-1:0] rd_addr_o,
  output logic [PTR_W-1:0] sp_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             err_o
);

  function automatic logic [PTR_W-1:0] ptr_up(input logic [PTR_W-1:0] p);
    return p + PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] ptr_down(input logic [PTR_W-1:0] p);
    return p - PTR_W'(1);
  endfunction

  logic [PTR_W-1:0] sp_q;
  logic             full_q;
  logic             empty_q;
  logic             err_q;
  logic [PTR_W-1:0] sp_up;
  logic [PTR_W-1:0] sp_dn;
  req_e             req;

  always_comb begin
    req   = classify(push_i, pop_i, full_q, empty_q);
    sp_up = ptr_up(sp_q);
    sp_dn = ptr_down(sp_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q    <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      err_q <= (req == REQ_BAD);
      case (req)
        REQ_PUSH: begin
          sp_q    <= sp_up;
          full_q  <= (sp_up == '0);
          empty_q <= 1'b0;
        end
        REQ_POP: begin
          sp_q    <= sp_dn;
          empty_q <= (sp_dn == '0);
          full_q  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign do_push_o = (req == REQ_PUSH);
  assign do_pop_o  = (req == REQ_POP);
  assign bad_req_o = (req == REQ_BAD);
  assign wr_addr_o = sp_up;
  assign rd_addr_o = sp_q;
  assign sp_o      = sp_q;
  assign full_o    = full_q;
  assign empty_o   = empty_q;
  assign err_o     = err_q;

endmodule

// File: rtl/lifo_regstack.sv
module lifo_regstack #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              full_o,
  output logic              empty_o,
  output logic              err_o
);

  logic             do_push;
  logic             do_pop;
  logic             bad_req;
  logic [PTR_W-1:0] wr_addr;
  logic [PTR_W-1:0] rd_addr;
  logic [PTR_W-1:0] sp_w;

  lifo_regstack_ctrl #(.PTR_W(PTR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (push_i),
    .pop_i     (pop_i),
    .do_push_o (do_push),
    .do_pop_o  (do_pop),
    .bad_req_o (bad_req),
    .wr_addr_o (wr_addr),
    .rd_addr_o (rd_addr),
    .sp_o      (sp_w),
    .full_o    (full_o),
    .empty_o   (empty_o),
    .err_o     (err_o)
  );

  lifo_regstack_store #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (do_push),
    .waddr_i (wr_addr),
    .wdata_i (wr_data),
    .re_i    (do_pop),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

endmodule

// File: rtl/lifo_regstack_chk.sv
module lifo_regstack_chk #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_i,
  input logic              pop_i,
  input logic [DATA_W-1:0] rd_data,
  input logic              full_o,
  input logic              empty_o,
  input logic              err_o,
  input logic              do_push,
  input logic              do_pop,
  input logic              bad_req,
  input logic [PTR_W-1:0]  sp
);

  p_flags_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_o && empty_o));

  p_push_clears_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !full_o) |=> !empty_o);

  p_full_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> (sp == '0));

  p_pop_clears_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !empty_o) |=> !full_o);

  p_empty_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o |-> (sp == '0));

  p_push_full_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && full_o) |=> (err_o && full_o && $stable(rd_data)));

  p_pop_empty_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && empty_o) |=> (err_o && empty_o && $stable(rd_data)));

  p_both_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |=> (err_o && $stable(sp) && $stable(rd_data)));

  p_one_action_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({do_push, do_pop, bad_req}));

  p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_i && !pop_i) |=> !err_o);

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !do_pop |=> $stable(rd_data));

endmodule

bind lifo_regstack lifo_regstack_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .push_i  (push_i),
  .pop_i   (pop_i),
  .rd_data (rd_data),
  .full_o  (full_o),
  .empty_o (empty_o),
  .err_o   (err_o),
  .do_push (do_push),
  .do_pop  (do_pop),
  .bad_req (bad_req),
  .sp      (sp_w)
);

// File: tb/lifo_regstack_test.sv
`timescale 1ns/1ps
module lifo_regstack_test;
  localparam int DW  = 8;
  localparam int CAP = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push_i = 1'b0;
  logic          pop_i = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          full_o, empty_o, err_o;

  int total = 0;
  int bad = 0;

  // Reference: occupancy count and a plain array indexed by depth.
  logic [DW-1:0] ref_stk [CAP];
  int            ref_cnt = 0;
  logic [DW-1:0] ref_rd = '0;
  logic          ref_err = 1'b0;

  lifo_regstack uut (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
    .wr_data(wr_data), .rd_data(rd_data), .full_o(full_o),
    .empty_o(empty_o), .err_o(err_o)
  );

  always #10 clk = ~clk;

  function automatic bit rejects(input bit ps, input bit pp, input int cnt);
    return (ps && pp) || (ps && cnt == CAP) || (pp && cnt == 0);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One cycle: drive after the falling edge, compare just after the rising edge.
  task automatic step(input bit ps, input bit pp, input logic [DW-1:0] d,
                      input string rd_tag);
    string etag, dtag;
    bit    acc_pop;
    @(negedge clk);
    push_i  = ps;
    pop_i   = pp;
    wr_data = d;
    acc_pop = 1'b0;
    if (rejects(ps, pp, ref_cnt)) begin
      ref_err = 1'b1;
      etag = (ps && pp) ? "R7" : (ps ? "R5" : "R6");
    end else begin
      ref_err = 1'b0;
      etag = "R8";
      if (ps) begin
        ref_stk[ref_cnt] = d;
        ref_cnt++;
      end else if (pp) begin
        ref_cnt--;
        ref_rd  = ref_stk[ref_cnt];
        acc_pop = 1'b1;
      end
    end
    dtag = acc_pop ? rd_tag : "R9";
    @(posedge clk);
    #2;
    check(err_o == ref_err, etag, "err", int'(err_o), int'(ref_err));
    check(rd_data == ref_rd, dtag, "rd_data", int'(rd_data), int'(ref_rd));
    check(full_o == (ref_cnt == CAP), ps ? "R3" : "R4", "full",
          int'(full_o), int'(ref_cnt == CAP));
    check(empty_o == (ref_cnt == 0), pp ? "R4" : "R3", "empty",
          int'(empty_o), int'(ref_cnt == 0));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2;
    check(empty_o == 1'b1 && full_o == 1'b0 && err_o == 1'b0 && rd_data == '0,
          "R1", "reset state", int'({empty_o, full_o, err_o}), 4);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    check(empty_o && !full_o && !err_o && rd_data == '0, "R1",
          "after release", int'({empty_o, full_o, err_o}), 4);

    // Rejects on an empty store, then an idle cycle clears the pulse.
    step(1'b0, 1'b1, 8'h00, "R6");
    step(1'b0, 1'b0, 8'h00, "R8");
    step(1'b1, 1'b1, 8'h5A, "R7");
    step(1'b0, 1'b1, 8'h00, "R6");

    // Fill all 64 positions; the last write goes to pointer 0.
    for (int i = 0; i < CAP; i++) step(1'b1, 1'b0, DW'(i * 7 + 3), "R3");
    step(1'b1, 1'b0, 8'hEE, "R5");
    step(1'b1, 1'b0, 8'hDD, "R5");
    step(1'b1, 1'b1, 8'hCC, "R7");
    step(1'b0, 1'b0, 8'h00, "R8");

    // Drain completely; order must be exactly reversed.
    for (int i = 0; i < CAP; i++) step(1'b0, 1'b1, 8'h00, "R10");
    step(1'b0, 1'b1, 8'h00, "R6");

    // Push-pop around the boundaries at single depth.
    step(1'b1, 1'b0, 8'hA5, "R2");
    step(1'b0, 1'b1, 8'h00, "R2");

    // Random phases biased toward filling, draining and balanced use.
    for (int ph = 0; ph < 12; ph++) begin
      int pw;
      pw = (ph % 3 == 0) ? 80 : ((ph % 3 == 1) ? 20 : 50);
      for (int k = 0; k < 250; k++) begin
        int  r;
        bit  ps, pp;
        r  = int'($urandom_range(99));
        ps = (r < pw);
        pp = !ps && (r < 95);
        if (($urandom_range(29)) == 0) begin
          ps = 1'b1;
          pp = 1'b1;
        end
        step(ps, pp, DW'($urandom), "R2");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule